// File: doc/BRIEF.md
# Serial Bitstream Input Receiver

This block is the front end for a one-bit data stream coming from an external modulator. It turns the stream into recovered data bits. Each bit is presented for one system clock cycle together with a valid strobe. Two families of operation are supported:

- **Clocked-serial capture.** The data pin is sampled on a chosen edge of a serial clock. That clock is either an external clock pin or a clock the block generates and drives out.
- **Manchester decoding.** The bit value comes from the direction of the mid-bit transition. Intervals are timed with the system clock.

The generated clock is the system clock divided by an even ratio. The ratio is `2 * div_half_i`. Two clock-source settings capture only on every second falling edge, or every second rising edge, of the generated clock. The external clock pin and the data pin each pass through a two-flop synchronizer, and all edge detection happens in the system clock domain. The system clock must run at least four times faster than the serial clock.

Clock-source and interface-type settings are loaded through a write strobe. They are taken only while the channel is disabled. `div_half_i` must be held steady while the channel is enabled.

Top module: `sbit_rx`

## Requirements
- R1: Configuration is loaded from `cfg_src_i`/`cfg_mode_i` on a `cfg_wr_i` cycle only while `chan_en_i` is low. A write while enabled is ignored. After reset both settings are 0 (external clock, rising-edge clocked-serial).
- R2: With source 0 (external clock) and mode 0, one bit is captured per rising edge of `ext_clk_i`. The captured value is the data level at that edge.
- R3: With source 0 and mode 1, one bit is captured per falling edge of `ext_clk_i`.
- R4: While enabled, `int_clk_o` starts low and toggles every `div_half_i` system cycles. `div_half_i` must be at least 2. While disabled, `int_clk_o` is held low.
- R5: With source 1 (generated clock), modes 0 and 1 capture on the rising and falling edges of `int_clk_o` respectively.
- R6: Source 2 captures on every second falling edge of `int_clk_o`, and source 3 on every second rising edge, whatever the mode's edge bit says. The edge parity restarts at each enable, so the first capture is on the second qualifying edge after enable.
- R7: Mode 2 is Manchester decoding with a rising transition giving 0 and a falling transition giving 1. Mode 3 swaps this, so rising gives 1 and falling gives 0.
- R8: In Manchester modes, a transition arriving less than 1.5·`div_half_i` cycles after the last accepted transition is a bit-boundary transition and produces no bit. The Manchester bit period is 2·`div_half_i` system cycles. The first transition after enable is taken as a mid-bit transition.
- R9: `bit_vld_o` is a single-cycle pulse per recovered bit. It stays low from the cycle after `chan_en_i` falls until the channel is enabled again.
- R10: During and after reset, `bit_vld_o` and `int_clk_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 1 | Channel enable |
| cfg_wr_i | input | 1 | Load strobe for the clock-source and interface-type settings |
| cfg_src_i | input | 2 | Clock source: 0 external, 1 generated, 2 generated every 2nd fall, 3 generated every 2nd rise |
| cfg_mode_i | input | 2 | Interface type: 0 rise capture, 1 fall capture, 2 Manchester rise=0, 3 Manchester rise=1 |
| div_half_i | input | DIV_W | Half period of the generated clock, in system cycles (>= 2) |
| ext_clk_i | input | 1 | External serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| int_clk_o | output | 1 | Generated serial clock |
| bit_o | output | 1 | Recovered bit |
| bit_vld_o | output | 1 | One-cycle valid for `bit_o` |

## Verification
The bench checks what each corner case would look like if the design got it wrong:

- **Wrong edge.** The data line changes on the edge opposite to the sampling edge. A design that samples on the wrong edge returns the bit stream shifted by one position.
- **Parity not restarted.** Each every-second-edge run is stopped after an odd number of qualifying edges, then the channel is re-enabled. A design that keeps the parity across enables picks the wrong half of the edges.
- **Configuration write while enabled.** The bench writes a new configuration during a live rising-edge capture. A design that accepts the write starts sampling on falling edges and corrupts the stream.
- **Manchester boundaries and polarity.** The Manchester patterns contain runs of equal bits, which force boundary transitions. A design that decodes those produces extra bits. A design with swapped polarity produces inverted data.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int unsigned SBR_DIV_W = 8;

  typedef enum logic [1:0] {
    SRC_EXT    = 2'd0,
    SRC_INT    = 2'd1,
    SRC_INT_F2 = 2'd2,
    SRC_INT_R2 = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    IF_RISE   = 2'd0,
    IF_FALL   = 2'd1,
    IF_MCH_R0 = 2'd2,
    IF_MCH_R1 = 2'd3
  } if_mode_e;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign lvl_o[g] = sync_q[g];
    assign chg_o[g] = sync_q[g] ^ prev_q[g];
  end
endmodule

// File: rtl/sbr_clkgen.sv
module sbr_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             last, tick;

  assign last = (cnt_q == div_half_i - DIV_W'(1));
  assign tick = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (last) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;

  a_r4_div_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (div_half_i >= DIV_W'(2)));
  a_r4_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_q);
  a_r4_toggle_on_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sclk_q != $past(sclk_q)))
      |-> ($past(cnt_q) == $past(div_half_i) - DIV_W'(1)));
endmodule

// File: rtl/sbr_capture.sv
module sbr_capture
  import sbr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  clk_src_e src_i,
  input  logic     fall_sel_i,
  input  logic     ext_lvl_i,
  input  logic     ext_chg_i,
  input  logic     int_rise_i,
  input  logic     int_fall_i,
  input  logic     data_i,
  output logic     bit_o,
  output logic     vld_o
);
  logic ext_rise, ext_fall, edge_hit, take;
  logic par_q, vld_q, bit_q;

  assign ext_rise = ext_chg_i && ext_lvl_i;
  assign ext_fall = ext_chg_i && !ext_lvl_i;

  always_comb begin
    unique case (src_i)
      SRC_EXT:    edge_hit = fall_sel_i ? ext_fall   : ext_rise;
      SRC_INT:    edge_hit = fall_sel_i ? int_fall_i : int_rise_i;
      SRC_INT_F2: edge_hit = int_fall_i;
      SRC_INT_R2: edge_hit = int_rise_i;
      default:    edge_hit = 1'b0;
    endcase
  end

  // paired modes keep only every second qualifying edge
  assign take = edge_hit && (!src_i[1] || par_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0;
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else if (!en_i) begin
      par_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) bit_q <= data_i;
      if (edge_hit && src_i[1]) par_q <= ~par_q;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

  a_r6_second_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && src_i[1]) |-> !par_q);
endmodule

// File: rtl/sbr_manch.sv
module sbr_manch #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [DIV_W-1:0] div_half_i,
  input  logic             lvl_i,
  input  logic             chg_i,
  output logic             bit_o,
  output logic             vld_o
);
  localparam int unsigned CW = DIV_W + 2;

  logic [CW-1:0] cnt_q, thr;
  logic          armed_q, vld_q, bit_q, take;

  // mid-bit window opens at three quarters of a bit period
  assign thr  = CW'(div_half_i) + CW'(div_half_i >> 1);
  assign take = chg_i && (!armed_q || (cnt_q >= thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      bit_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) begin
        bit_q   <= pol_i ? lvl_i : ~lvl_i;
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

  a_r8_boundary_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (!$past(armed_q) || ($past(cnt_q) >= $past(thr))));
endmodule

// File: rtl/sbit_rx.sv
module sbit_rx
  import sbr_pkg::*;
#(
  parameter int unsigned DIV_W = SBR_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_en_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_src_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [DIV_W-1:0] div_half_i,
  input  logic             ext_clk_i,
  input  logic             sdata_i,
  output logic             int_clk_o,
  output logic             bit_o,
  output logic             bit_vld_o
);
  clk_src_e   src_q;
  if_mode_e   mode_q;
  logic [1:0] s_lvl, s_chg;
  logic       irise, ifall, cap_en, mch_en;
  logic       c_bit, c_vld, m_bit, m_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= SRC_EXT;
      mode_q <= IF_RISE;
    end else if (cfg_wr_i && !chan_en_i) begin
      src_q  <= clk_src_e'(cfg_src_i);
      mode_q <= if_mode_e'(cfg_mode_i);
    end
  end

  assign cap_en = chan_en_i && !mode_q[1];
  assign mch_en = chan_en_i && mode_q[1];

  // bit 1: data, bit 0: external clock
  sbr_sync #(.W(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdata_i, ext_clk_i}),
    .lvl_o   (s_lvl),
    .chg_o   (s_chg)
  );

  sbr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (chan_en_i),
    .div_half_i (div_half_i),
    .sclk_o     (int_clk_o),
    .rise_o     (irise),
    .fall_o     (ifall)
  );

  sbr_capture u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cap_en),
    .src_i      (src_q),
    .fall_sel_i (mode_q[0]),
    .ext_lvl_i  (s_lvl[0]),
    .ext_chg_i  (s_chg[0]),
    .int_rise_i (irise),
    .int_fall_i (ifall),
    .data_i     (s_lvl[1]),
    .bit_o      (c_bit),
    .vld_o      (c_vld)
  );

  sbr_manch #(.DIV_W(DIV_W)) u_manch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mch_en),
    .pol_i      (mode_q[0]),
    .div_half_i (div_half_i),
    .lvl_i      (s_lvl[1]),
    .chg_i      (s_chg[1]),
    .bit_o      (m_bit),
    .vld_o      (m_vld)
  );

  assign bit_o     = mode_q[1] ? m_bit : c_bit;
  assign bit_vld_o = mode_q[1] ? m_vld : c_vld;

  a_r1_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(chan_en_i) |-> ($stable(src_q) && $stable(mode_q)));
  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_en_i && !$past(chan_en_i)) |-> !bit_vld_o);
  a_r9_single_pulse_clocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_o && !mode_q[1]) |=> !bit_vld_o);
endmodule

// File: tb/sim_sbit_rx.sv
`timescale 1ns/1ps
module sim_sbit_rx;
  localparam int DIVH = 4;
  localparam logic [15:0] PAT = 16'hB4D3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_src = 2'd0;
  logic [1:0] cfg_mode = 2'd0;
  logic [7:0] div_half = 8'(DIVH);
  logic       ext_clk = 1'b0;
  logic       tsk_data = 1'b0;
  logic       drv_int = 1'b0;
  logic       use_int = 1'b0;
  logic       sdata_w;
  logic       int_clk, bit_out, bit_vld;

  int checks = 0;
  int fails = 0;

  assign sdata_w = use_int ? drv_int : tsk_data;

  always #10 clk = ~clk;

  sbit_rx u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .chan_en_i  (chan_en),
    .cfg_wr_i   (cfg_wr),
    .cfg_src_i  (cfg_src),
    .cfg_mode_i (cfg_mode),
    .div_half_i (div_half),
    .ext_clk_i  (ext_clk),
    .sdata_i    (sdata_w),
    .int_clk_o  (int_clk),
    .bit_o      (bit_out),
    .bit_vld_o  (bit_vld)
  );

  // monitor: samples mid high phase, away from both edges
  logic       rx_bits [0:255];
  logic       exp_bits[0:255];
  int         rx_n = 0, exp_n = 0, dbl = 0, cyc = 0, last_t = 0, last_gap = 0, drv_i = 0;
  logic       prev_vld = 1'b0, prev_ick = 1'b0, mon_par = 1'b0;
  logic [1:0] mon_src = 2'd0, mon_mode = 2'd0;

  always @(posedge clk) begin : mon
    logic is_r, samp, take;
    #5;
    cyc++;
    if (bit_vld) begin
      if (rx_n < 256) rx_bits[rx_n] = bit_out;
      rx_n++;
      if (prev_vld) dbl++;
    end
    prev_vld = bit_vld;
    if (!chan_en) begin
      mon_par = 1'b0;
      drv_i   = 0;
    end else if (int_clk != prev_ick) begin
      last_gap = cyc - last_t;
      last_t   = cyc;
      is_r = int_clk;
      samp = (mon_src == 2'd2) ? !is_r :
             (mon_src == 2'd3) ? is_r  : (mon_mode[0] ? !is_r : is_r);
      if (samp) begin
        take = 1'b1;
        if (mon_src[1]) begin
          take    = mon_par;
          mon_par = !mon_par;
        end
        if (take) begin
          if (exp_n < 256) exp_bits[exp_n] = sdata_w;
          exp_n++;
        end
      end else if (use_int) begin
        drv_int = PAT[drv_i % 16];
        drv_i++;
      end
    end
    prev_ick = int_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [1:0] m);
    @(negedge clk);
    cfg_src = s; cfg_mode = m; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cmp_pat(input string req, input int base, input int n, input logic [15:0] p);
    int bad = 0;
    chk(rx_n - base == n, {req, " bit count"}, rx_n - base, n);
    for (int i = 0; i < n; i++)
      if (base + i < rx_n && rx_bits[base + i] != p[i]) bad++;
    chk(bad == 0, {req, " bit values mismatches"}, bad, 0);
  endtask

  task automatic cmp_mon(input string req, input int rb, input int eb);
    int bad = 0;
    int n = exp_n - eb;
    chk((rx_n - rb == n) && (n >= 4), {req, " bit count"}, rx_n - rb, n);
    for (int i = 0; i < n; i++)
      if (rb + i < rx_n && rx_bits[rb + i] != exp_bits[eb + i]) bad++;
    chk(bad == 0, {req, " bit values mismatches"}, bad, 0);
  endtask

  // R1 default config and lock, R2 external rising capture
  task automatic t_ext_rise();
    int base = rx_n;
    ext_clk = 1'b0;
    wait_cyc(4);
    chan_en = 1'b1;
    wait_cyc(2);
    cfg_src = 2'd0; cfg_mode = 2'd1; cfg_wr = 1'b1;  // must be ignored (R1)
    wait_cyc(1);
    cfg_wr = 1'b0;
    for (int i = 0; i < 12; i++) begin
      ext_clk = 1'b0; tsk_data = PAT[i];
      wait_cyc(4);
      ext_clk = 1'b1;
      wait_cyc(4);
    end
    wait_cyc(6);
    chan_en = 1'b0;
    wait_cyc(4);
    cmp_pat("R1 R2 ext rise with locked cfg", base, 12, PAT);
  endtask

  // R3 external falling capture
  task automatic t_ext_fall();
    int base;
    set_cfg(2'd0, 2'd1);
    ext_clk = 1'b1;
    wait_cyc(4);
    base = rx_n;
    chan_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      ext_clk = 1'b1; tsk_data = ~PAT[i];
      wait_cyc(4);
      ext_clk = 1'b0;
      wait_cyc(4);
    end
    wait_cyc(6);
    chan_en = 1'b0;
    wait_cyc(4);
    cmp_pat("R3 ext fall", base, 12, ~PAT);
  endtask

  // R5, R6: generated clock capture; paired modes stop after an odd edge count
  task automatic t_int(input logic [1:0] s, input logic [1:0] m, input string req);
    int rb, eb;
    set_cfg(s, m);
    mon_src = s; mon_mode = m; use_int = 1'b1;
    wait_cyc(2);
    rb = rx_n; eb = exp_n;
    chan_en = 1'b1;
    while (drv_i < 14) @(negedge clk);
    wait_cyc(2 * DIVH + 2);
    if (s[1]) while (!mon_par) @(negedge clk);
    chan_en = 1'b0;
    wait_cyc(4);
    use_int = 1'b0;
    cmp_mon(req, rb, eb);
  endtask

  // R7, R8: Manchester with boundary transitions from repeated bits
  task automatic t_manch(input logic pol, input logic [15:0] p, input int n, input string req);
    int base;
    set_cfg(2'd0, {1'b1, pol});
    tsk_data = pol ? ~p[0] : p[0];
    wait_cyc(6);
    base = rx_n;
    chan_en = 1'b1;
    wait_cyc(6);
    for (int i = 0; i < n; i++) begin
      tsk_data = pol ? ~p[i] : p[i];
      wait_cyc(DIVH);
      tsk_data = ~tsk_data;
      wait_cyc(DIVH);
    end
    wait_cyc(8);
    chan_en = 1'b0;
    wait_cyc(4);
    cmp_pat(req, base, n, p);
  endtask

  // R9: nothing recovered while disabled
  task automatic t_quiet();
    int base = rx_n;
    int hi = 0;
    set_cfg(2'd1, 2'd0);
    for (int i = 0; i < 16; i++) begin
      ext_clk = ~ext_clk; tsk_data = PAT[i];
      wait_cyc(3);
      if (int_clk) hi++;
    end
    chk(rx_n == base, "R9 no valid while disabled", rx_n - base, 0);
    chk(hi == 0, "R4 int_clk low while disabled", hi, 0);
    chk(dbl == 0, "R9 valid pulses are single-cycle", dbl, 0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    chk(bit_vld == 1'b0, "R10 reset valid", int'(bit_vld), 0);
    chk(int_clk == 1'b0, "R10 reset int_clk", int'(int_clk), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(bit_vld == 1'b0 && int_clk == 1'b0, "R10 after reset",
        int'({int_clk, bit_vld}), 0);

    t_ext_rise();
    t_ext_fall();
    t_int(2'd1, 2'd0, "R5 int rise");
    chk(last_gap == DIVH, "R4 int_clk half period", last_gap, DIVH);
    t_int(2'd1, 2'd1, "R5 int fall");
    t_int(2'd2, 2'd0, "R6 every 2nd fall");
    t_int(2'd2, 2'd0, "R6 every 2nd fall after re-enable");
    t_int(2'd3, 2'd1, "R6 every 2nd rise");
    t_int(2'd3, 2'd1, "R6 every 2nd rise after re-enable");
    t_manch(1'b0, 16'h3C65, 14, "R7 R8 manchester rise=0");
    t_manch(1'b1, 16'h0E93, 14, "R7 R8 manchester rise=1");
    t_quiet();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule